// File: doc/BRIEF.md
# Remote CPU Start Controller

This block lets one processor in a multi-core cluster bring up the others. Software writes a 32-bit value into a parameter register and then issues commands through a command register. Each command word names a target core in bits 15:8 and carries an operation code in bits 7:0. Setting a core's start address is one command. Releasing that core from halt is a second command. The normal boot of a secondary core is therefore three writes in order: the start address into the parameter register, a set-start-address command for the core, and then a release command for the same core.

For every core the block drives a held start address, a single-cycle load strobe that marks a new address, and a run level. It also drives the complement of the run levels as a halt bitmask that software can read back. The number of cores is a parameter and defaults to four. After reset only core 0 runs.

Top module: `rcs_start_ctrl`

## Requirements
- R1: After reset, core 0 runs, every other core is halted, every start address is zero and every load strobe is low.
- R2: A parameter write stores the value, and it appears on `param_value` one cycle later.
- R3: The set-start-address command (code 0x04) copies the parameter value held before that clock edge into the target core's start address. The other cores' addresses do not change.
- R4: A set-start-address command raises the target core's `pc_load` bit for exactly the one cycle after the command. No other core's bit rises.
- R5: The release command (code 0x02) sets the target core's run level one cycle after the command. The set-start-address command never changes a run level.
- R6: A command whose index (bits 15:8) is at or above NUM_CPUS changes no output.
- R7: A command whose code is neither 0x02 nor 0x04 changes no output.
- R8: Bit i of `halt_mask` is 1 exactly when core i is halted.
- R9: When a parameter write and a set-start-address command arrive in the same cycle, the command uses the old parameter value, and the new value is stored for later.
- R10: Releasing a core that already runs leaves every output unchanged, and no command halts a running core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| param_we | input | 1 | Parameter register write enable |
| param_wdata | input | PC_W | Value to store in the parameter register |
| cmd_we | input | 1 | Command register write enable |
| cmd_word | input | IDX_W+8 | Command word: target index in the upper field, operation code in the low 8 bits |
| param_value | output | PC_W | Current parameter register contents |
| start_pc | output | NUM_CPUS*PC_W | Start addresses; core i uses slice [i*PC_W +: PC_W] |
| pc_load | output | NUM_CPUS | One-cycle strobe per core when its start address is written |
| cpu_run | output | NUM_CPUS | Run level per core (1 = running) |
| halt_mask | output | NUM_CPUS | Halt bitmask per core (1 = halted) |

## Verification
The bench issues a parameter write and a set-start-address command in the same cycle. A design that forwards the new value into the command would load the wrong address into the core. It sends commands with the index just past the last core and with the all-ones index. A decoder that truncates the index would then load or release a core that was never named. It sends unknown codes, including 0x03 and 0x06, which sit next to the valid ones, and it releases a core that already runs. Each of these would show up as a stray strobe, a changed address or a flipped run bit. It also checks that the load strobe drops after one cycle and that a later command leaves earlier cores' addresses untouched.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    // Width of the operation code field at the bottom of the command word
    localparam int CODE_W = 8;

    typedef enum logic [CODE_W-1:0] {
        RCS_OP_RELEASE = 8'h02,
        RCS_OP_SET_PC  = 8'h04
    } rcs_op_e;

endpackage

// File: rtl/rcs_cmd_decode.sv
module rcs_cmd_decode
    import rcs_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    parameter int IDX_W    = 8
) (
    input  logic                     cmd_we,
    input  logic [IDX_W+CODE_W-1:0]  cmd_word,
    output logic [NUM_CPUS-1:0]      set_pc_sel,
    output logic [NUM_CPUS-1:0]      release_sel
);

    logic [IDX_W-1:0]  idx;
    logic [CODE_W-1:0] code;
    logic              is_set_pc;
    logic              is_release;

    assign idx  = cmd_word[IDX_W+CODE_W-1:CODE_W];
    assign code = cmd_word[CODE_W-1:0];

    always_comb begin
        is_set_pc  = cmd_we && (code == RCS_OP_SET_PC);
        is_release = cmd_we && (code == RCS_OP_RELEASE);
        set_pc_sel  = '0;
        release_sel = '0;
        // Full-width index compare: indices past the last core match nothing
        for (int i = 0; i < NUM_CPUS; i++) begin
            if (idx == IDX_W'(i)) begin
                set_pc_sel[i]  = is_set_pc;
                release_sel[i] = is_release;
            end
        end
    end

endmodule

// File: rtl/rcs_cpu_slot.sv
module rcs_cpu_slot #(
    parameter int   PC_W      = 32,
    parameter logic RESET_RUN = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_pc,
    input  logic            release_req,
    input  logic [PC_W-1:0] param_value,
    output logic [PC_W-1:0] start_pc,
    output logic            pc_load,
    output logic            cpu_run
);

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            load;
        logic            run;
    } slot_t;

    slot_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.load = set_pc;
        if (set_pc) begin
            state_d.pc = param_value;
        end
        if (release_req) begin
            state_d.run = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.pc   <= '0;
            state_q.load <= 1'b0;
            state_q.run  <= RESET_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    assign start_pc = state_q.pc;
    assign pc_load  = state_q.load;
    assign cpu_run  = state_q.run;

    // Address only moves in the cycle its strobe is shown
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_load |-> $stable(start_pc)); // R3

    // A running core never returns to halt
    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cpu_run) |-> cpu_run); // R10

endmodule

// File: rtl/rcs_start_ctrl.sv
module rcs_start_ctrl
    import rcs_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    parameter int PC_W     = 32,
    parameter int IDX_W    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     param_we,
    input  logic [PC_W-1:0]          param_wdata,
    input  logic                     cmd_we,
    input  logic [IDX_W+CODE_W-1:0]  cmd_word,
    output logic [PC_W-1:0]          param_value,
    output logic [NUM_CPUS*PC_W-1:0] start_pc,
    output logic [NUM_CPUS-1:0]      pc_load,
    output logic [NUM_CPUS-1:0]      cpu_run,
    output logic [NUM_CPUS-1:0]      halt_mask
);

    localparam int CMD_W = IDX_W + CODE_W;

    typedef struct packed {
        logic [PC_W-1:0] param;
    } top_t;

    top_t top_d, top_q;

    logic [NUM_CPUS-1:0] set_pc_sel;
    logic [NUM_CPUS-1:0] release_sel;

    always_comb begin
        top_d = top_q;
        if (param_we) begin
            top_d.param = param_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign param_value = top_q.param;

    rcs_cmd_decode #(
        .NUM_CPUS (NUM_CPUS),
        .IDX_W    (IDX_W)
    ) u_decode (
        .cmd_we      (cmd_we),
        .cmd_word    (cmd_word),
        .set_pc_sel  (set_pc_sel),
        .release_sel (release_sel)
    );

    for (genvar g = 0; g < NUM_CPUS; g++) begin : g_slot
        rcs_cpu_slot #(
            .PC_W      (PC_W),
            .RESET_RUN ((g == 0) ? 1'b1 : 1'b0)
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .set_pc      (set_pc_sel[g]),
            .release_req (release_sel[g]),
            .param_value (top_q.param),
            .start_pc    (start_pc[g*PC_W +: PC_W]),
            .pc_load     (pc_load[g]),
            .cpu_run     (cpu_run[g])
        );
    end

    assign halt_mask = ~cpu_run;

    logic [IDX_W-1:0]  cmd_idx;
    logic [CODE_W-1:0] cmd_code;
    assign cmd_idx  = cmd_word[CMD_W-1:CODE_W];
    assign cmd_code = cmd_word[CODE_W-1:0];

    AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pc_load)); // R4

    AST_BAD_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && (int'(cmd_idx) >= NUM_CPUS)) |=> (pc_load == '0) && $stable(cpu_run) && $stable(start_pc)); // R6

    AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && (cmd_code != RCS_OP_RELEASE) && (cmd_code != RCS_OP_SET_PC))
        |=> (pc_load == '0) && $stable(cpu_run) && $stable(start_pc)); // R7

    AST_SET_PC_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && (cmd_code == RCS_OP_SET_PC) && (int'(cmd_idx) < NUM_CPUS))
        |=> (pc_load != '0) && $stable(cpu_run)); // R5

endmodule

// File: tb/rcs_start_ctrl_test.sv
`timescale 1ns/1ps
module rcs_start_ctrl_test;

    localparam int N    = 4;
    localparam int PC_W = 32;

    typedef struct packed {
        logic [N*PC_W-1:0] pc;
        logic [N-1:0]      load;
        logic [N-1:0]      run;
        logic [PC_W-1:0]   param;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            param_we = 1'b0;
    logic [PC_W-1:0] param_wdata = '0;
    logic            cmd_we = 1'b0;
    logic [15:0]     cmd_word = '0;
    logic [PC_W-1:0] param_value;
    logic [N*PC_W-1:0] start_pc;
    logic [N-1:0]    pc_load, cpu_run, halt_mask;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    exp_t  exp_q[$];
    string tag_q[$];

    // reference model
    logic [N*PC_W-1:0] m_pc;
    logic [N-1:0]      m_run;
    logic [PC_W-1:0]   m_param;

    always #2.5 clk = ~clk;

    rcs_start_ctrl #(.NUM_CPUS(N), .PC_W(PC_W), .IDX_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .param_we(param_we), .param_wdata(param_wdata),
        .cmd_we(cmd_we), .cmd_word(cmd_word), .param_value(param_value),
        .start_pc(start_pc), .pc_load(pc_load), .cpu_run(cpu_run), .halt_mask(halt_mask)
    );

    task automatic compare(input exp_t e, input string tag);
        tests++;
        if (start_pc !== e.pc || pc_load !== e.load || cpu_run !== e.run ||
            halt_mask !== ~e.run || param_value !== e.param) begin
            fails++;
            $display("FAIL %s: pc=%h load=%b run=%b halt=%b param=%h expected pc=%h load=%b run=%b halt=%b param=%h",
                     tag, start_pc, pc_load, cpu_run, halt_mask, param_value,
                     e.pc, e.load, e.run, ~e.run, e.param);
        end
    endtask

    // driver: one cycle of stimulus, expected result pushed before the edge
    task automatic drive(input logic pwe, input logic [31:0] pdata,
                         input logic cwe, input logic [7:0] idx, input logic [7:0] code,
                         input string tag);
        exp_t e;
        logic [N-1:0] ld;
        ld = '0;
        @(negedge clk);
        param_we = pwe; param_wdata = pdata;
        cmd_we = cwe;   cmd_word = {idx, code};
        if (cwe && idx < 8'(N)) begin
            if (code == 8'h04) begin
                m_pc[idx*PC_W +: PC_W] = m_param;
                ld[idx] = 1'b1;
            end
            if (code == 8'h02) m_run[idx] = 1'b1;
        end
        if (pwe) m_param = pdata;
        e.pc = m_pc; e.load = ld; e.run = m_run; e.param = m_param;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk);
        @(negedge clk);
        param_we = 1'b0; cmd_we = 1'b0; cmd_word = '0;
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                compare(exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        exp_t r;
        m_pc = '0; m_run = 'b1; m_param = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        r.pc = '0; r.load = '0; r.run = 'b1; r.param = '0;
        compare(r, "R1 reset state");

        drive(1, 32'h1000_0000, 0, 8'd0, 8'h00, "R2 param write");
        drive(0, 0, 1, 8'd1, 8'h04, "R3 R4 set pc core1");
        drive(0, 0, 0, 8'd0, 8'h00, "R4 strobe drops");
        drive(0, 0, 1, 8'd1, 8'h02, "R5 R8 release core1");
        drive(1, 32'hDEAD_BEE0, 1, 8'd3, 8'h04, "R9 same-cycle param and set pc");
        drive(0, 0, 1, 8'd3, 8'h04, "R3 set pc core3 new value");
        drive(0, 0, 1, 8'd2, 8'h04, "R5 set pc keeps core2 halted");
        drive(1, 32'h0000_4000, 0, 8'd0, 8'h00, "R2 param rewrite");
        drive(0, 0, 1, 8'd4, 8'h04, "R6 index equal to count");
        drive(0, 0, 1, 8'd4, 8'h02, "R6 release index equal to count");
        drive(0, 0, 1, 8'hFF, 8'h02, "R6 all-ones index");
        drive(0, 0, 1, 8'h84, 8'h04, "R6 high index aliasing low bits");
        drive(0, 0, 1, 8'd2, 8'h03, "R7 code 0x03");
        drive(0, 0, 1, 8'd2, 8'h06, "R7 code 0x06");
        drive(0, 0, 1, 8'd3, 8'h00, "R7 code 0x00");
        drive(0, 0, 1, 8'd0, 8'h02, "R10 release running core0");
        drive(0, 0, 1, 8'd3, 8'h02, "R8 release core3");
        drive(0, 0, 1, 8'd0, 8'h04, "R3 set pc running core0");
        drive(0, 0, 1, 8'd2, 8'h02, "R8 release core2 all running");
        drive(0, 0, 1, 8'd1, 8'h02, "R10 second release core1");

        repeat (3) @(posedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule